// File: doc/BRIEF.md
# Serial Presence Detect Memory Slave

This block is a 256-byte configuration memory that answers as a slave on a two-wire serial bus. The clock (SCL) and data (SDA) lines are sampled by a fast system clock. Each line passes through a synchroniser and a glitch filter. An edge detector then finds bus START and STOP conditions and the rising and falling edges of SCL. The block drives SDA only low: `sda_oe_o` high means pull the line down, and a pull-up outside the block supplies the high level.

A master writes by sending the slave address with R/W = 0, then a word address, then any number of data bytes. A master reads from the current address, or first sets the address with a short write and then issues a repeated START to read. Reads continue for as long as the master acknowledges. One internal address pointer serves both reads and writes. Locations below a protection limit acknowledge writes but keep their contents. After a write that stored data and was closed by STOP, a busy timer blocks address acknowledges for a fixed number of cycles. This stands in for the storage cycle.

The control state machine has these states:
- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the acknowledge for the address.
- WORD: shifts in the word address.
- WORD_ACK: drives the acknowledge for the word address.
- WDATA: shifts in a data byte.
- WDATA_ACK: drives the acknowledge for a data byte.
- RDATA: shifts a byte out.
- RACK: samples the master's acknowledge.
- WAIT: releases the bus and ignores traffic.

Transitions:
- START moves any state to ADDR. STOP moves any state to IDLE.
- ADDR goes to ADDR_ACK on a hit, or to WAIT on a miss or while busy.
- ADDR_ACK goes to WORD for a write, or to RDATA for a read.
- WORD goes to WORD_ACK, then to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RACK. RACK goes back to RDATA on ACK, or to WAIT on NACK.

Top module: `spd_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is low and location a holds a XOR 8'hA5.
- R2: An address byte whose upper seven bits are 7'b1010000 is acknowledged (SDA low during the ninth SCL pulse). Any other address gets no acknowledge, and the block stays silent until the next START.
- R3: In a write, the byte after the address sets the pointer. Each later byte is acknowledged, stored at the pointer, and the pointer steps by one.
- R4: Writes to locations 0 to 127 are acknowledged but leave the stored value unchanged.
- R5: A read without a preceding word address returns the location one above the last accessed location.
- R6: A word-address write followed by a repeated START and an address byte with R/W = 1 reads from that word address, with no STOP in between.
- R7: Read data is sent MSB first. On an acknowledge from the master the next location follows, and the pointer wraps from 255 to 0.
- R8: After the master leaves a read byte unacknowledged, the block does not drive SDA until the next START.
- R9: STOP returns the block to idle. Clocked bytes that are not preceded by a START get no response and do not move the pointer.
- R10: Pulses on SCL or SDA shorter than FILT_CYCLES system clocks are ignored. An SDA glitch while SCL is high creates no START or STOP.
- R11: After a STOP that ends a write which stored at least one byte, address bytes are not acknowledged for BUSY_CYCLES system clocks. After that they are acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
Because the pointer is shared, a wrong pointer or a wrong stored byte shows up in the very next data byte read. The expected memory model catches it on that read. A state machine that falls out of step with the bit count shows as a missing or misplaced acknowledge within one byte time, or as SDA driven where the master expects a released line. A busy timer that is off shows in the first address probe after a write, and in how many probes the master needs before it gets an acknowledge.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } spd_state_e;

    localparam logic [3:0] SPD_DEV_TYPE = 4'b1010;

endpackage

// File: rtl/spd_line_filter.sv
module spd_line_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] != line_o) begin
                if (cnt_q == CW'(FILT_CYCLES - 1)) begin
                    line_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // R10: the filtered line only moves to a value the synchronised input held
    a_r10_follow_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> line_o == $past(sync_q[1]));

endmodule

// File: rtl/spd_bus_events.sv
module spd_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_i;
            sda_p <= sda_i;
        end
    end

    always_comb begin
        start_o = scl_i && scl_p && sda_p && !sda_i;
        stop_o  = scl_i && scl_p && !sda_p && sda_i;
        rise_o  = scl_i && !scl_p;
        fall_o  = !scl_i && scl_p;
    end

    // R9: at most one bus event per sampling cycle
    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, rise_o, fall_o}));

endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int         AW         = 8,
    parameter logic [7:0] INIT_XOR   = 8'hA5,
    parameter int         PROT_LIMIT = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic       wr_ok;

    assign wr_ok   = {1'b0, addr_i} >= (AW + 1)'(PROT_LIMIT);
    assign rdata_o = mem_q[addr_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'(i) ^ INIT_XOR;
            end
        end else if (we_i && wr_ok) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    // R4: protected locations keep their value through a write
    a_r4_protect_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ({1'b0, addr_i} < (AW + 1)'(PROT_LIMIT)))
            |=> mem_q[$past(addr_i)] == $past(mem_q[addr_i]));

endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave
    import spd_pkg::*;
#(
    parameter int         FILT_CYCLES = 4,
    parameter int         BUSY_CYCLES = 2000,
    parameter logic [2:0] DEV_SEL     = 3'b000,
    parameter logic [7:0] INIT_XOR    = 8'hA5,
    parameter int         PROT_LIMIT  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic [1:0] raw_w, filt_w;
    logic       scl_f, sda_f;
    logic       start_w, stop_w, rise_w, fall_w;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        spd_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_w[g]),
            .line_o (filt_w[g])
        );
    end

    assign scl_f = filt_w[0];
    assign sda_f = filt_w[1];

    spd_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_f),
        .sda_i   (sda_f),
        .start_o (start_w),
        .stop_o  (stop_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    spd_state_e    state_q, state_n;
    logic [3:0]    bit_cnt_q;
    logic [7:0]    shreg_q;
    logic [7:0]    ptr_q;
    logic          rw_q, wrote_q, mack_q, oe_q;
    logic [BW-1:0] busy_q;
    logic          addr_hit, byte_in_done, mem_we;
    logic [7:0]    rdata_w;

    assign addr_hit     = (shreg_q[7:1] == {SPD_DEV_TYPE, DEV_SEL}) && (busy_q == '0);
    assign byte_in_done = fall_w && (bit_cnt_q == 4'd8);
    assign mem_we       = (state_q == ST_WDATA) && byte_in_done;
    assign sda_oe_o     = oe_q;

    spd_store #(.AW(8), .INIT_XOR(INIT_XOR), .PROT_LIMIT(PROT_LIMIT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .addr_i  (ptr_q),
        .wdata_i (shreg_q),
        .rdata_o (rdata_w)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (stop_w) begin
            state_n = ST_IDLE;
        end else if (start_w) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_n = ST_IDLE;
                ST_ADDR:      if (byte_in_done) state_n = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  if (fall_w) state_n = rw_q ? ST_RDATA : ST_WORD;
                ST_WORD:      if (byte_in_done) state_n = ST_WORD_ACK;
                ST_WORD_ACK:  if (fall_w) state_n = ST_WDATA;
                ST_WDATA:     if (byte_in_done) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (fall_w) state_n = ST_WDATA;
                ST_RDATA:     if (fall_w && bit_cnt_q == 4'd7) state_n = ST_RACK;
                ST_RACK:      if (fall_w) state_n = mack_q ? ST_RDATA : ST_WAIT;
                ST_WAIT:      state_n = ST_WAIT;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            wrote_q   <= 1'b0;
            mack_q    <= 1'b0;
            oe_q      <= 1'b0;
            busy_q    <= '0;
        end else begin
            if (stop_w && wrote_q)  busy_q <= BW'(BUSY_CYCLES);
            else if (busy_q != '0)  busy_q <= busy_q - 1'b1;

            if (stop_w || start_w) begin
                oe_q      <= 1'b0;
                bit_cnt_q <= '0;
                wrote_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        if (rise_w && bit_cnt_q != 4'd8) begin
                            shreg_q   <= {shreg_q[6:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (byte_in_done) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    oe_q <= 1'b1;
                                    rw_q <= shreg_q[0];
                                end
                            end else if (state_q == ST_WORD) begin
                                oe_q  <= 1'b1;
                                ptr_q <= shreg_q;
                            end else begin
                                oe_q    <= 1'b1;
                                ptr_q   <= ptr_q + 1'b1;
                                wrote_q <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (fall_w) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                shreg_q <= rdata_w;
                                oe_q    <= ~rdata_w[7];
                                ptr_q   <= ptr_q + 1'b1;
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_WORD_ACK, ST_WDATA_ACK: begin
                        if (fall_w) begin
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (fall_w) begin
                            if (bit_cnt_q == 4'd7) begin
                                oe_q <= 1'b0;
                            end else begin
                                shreg_q   <= {shreg_q[6:0], 1'b0};
                                oe_q      <= ~shreg_q[6];
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (rise_w) mack_q <= ~sda_f;
                        if (fall_w) begin
                            bit_cnt_q <= '0;
                            if (mack_q) begin
                                shreg_q <= rdata_w;
                                oe_q    <= ~rdata_w[7];
                                ptr_q   <= ptr_q + 1'b1;
                            end else begin
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_IDLE, ST_WAIT: oe_q <= 1'b0;
                    default:          oe_q <= 1'b0;
                endcase
            end
        end
    end

    // R2: SDA is pulled only in acknowledge slots or while sending data
    a_r2_oe_in_drive_states: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> (state_q inside {ST_ADDR_ACK, ST_WORD_ACK, ST_WDATA_ACK, ST_RDATA}));

    // R8: released bus after a NACK or a miss
    a_r8_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !oe_q);

    // R11: an address acknowledge never starts while the busy timer runs
    a_r11_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ADDR_ACK) |-> $past(busy_q) == '0);

    // R3: every stored byte advances the pointer by one
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr_q == $past(ptr_q) + 8'd1);

endmodule

// File: tb/spd_eeprom_slave_tb.sv
module spd_eeprom_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 20;
    localparam int BUSY       = 2000;
    localparam logic [7:0] XORV = 8'hA5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, glitch_n = 1'b1;
    logic sda_oe, sda_line;
    logic glitch_en = 1'b0;

    assign sda_line = sda_m & glitch_n & ~sda_oe;

    spd_eeprom_slave #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [256];
    logic [7:0] ptr_m = 8'd0;
    logic [7:0] wbuf [8];
    bit done = 1'b0;
    int cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bit_out(input bit b, output bit seen);
        tick(4); sda_m = b; tick(H - 4);
        scl_m = 1'b1; tick(H / 2 - 4);
        if (glitch_en && b) begin
            glitch_n = 1'b0; tick(2); glitch_n = 1'b1; tick(2);
        end else begin
            tick(4);
        end
        seen = sda_line; tick(H / 2); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) bit_out(b[i], s);
        bit_out(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        bit s;
        for (int i = 0; i < 8; i++) begin
            bit_out(1'b1, s);
            b = {b[6:0], s};
        end
        bit_out(!give_ack, s);
    endtask

    task automatic poll_ready(output int tries);
        bit a;
        tries = 0;
        for (int t = 0; t < 40; t++) begin
            i2c_start(); send_byte(8'hA0, a); i2c_stop();
            tries++;
            if (a) break;
        end
    endtask

    task automatic do_write(input logic [7:0] addr, input int n, input string tag);
        bit a;
        int tries;
        i2c_start();
        send_byte(8'hA0, a); check(a, "R2 write address ack", a, 1);
        send_byte(addr, a);  check(a, "R3 word address ack", a, 1);
        ptr_m = addr;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);
            check(a, {tag, " data ack"}, a, 1);
            if (ptr_m >= 8'd128) model[ptr_m] = wbuf[i];
            ptr_m++;
        end
        i2c_stop();
        poll_ready(tries);
        check(tries < 40, "R11 ready after busy", tries, 40);
    endtask

    task automatic read_run(input bit random, input logic [7:0] addr, input int n,
                            input string tag);
        bit a;
        logic [7:0] d;
        i2c_start();
        if (random) begin
            send_byte(8'hA0, a); check(a, "R6 dummy write ack", a, 1);
            send_byte(addr, a);  check(a, "R6 word ack", a, 1);
            ptr_m = addr;
            i2c_start();
        end
        send_byte(8'hA1, a); check(a, "R2 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check(d == model[ptr_m], tag, d, model[ptr_m]);
            ptr_m++;
        end
        i2c_stop();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit a;
        int tries;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ XORV;

        tick(5);
        check(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(20);
        check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

        // R1, R6: reset contents through a random read
        read_run(1'b1, 8'h00, 1, "R1 reset content");
        // R5: current address continues after last access
        read_run(1'b0, 8'h00, 1, "R5 current address read");

        // R2: wrong select bits and wrong device type
        i2c_start(); send_byte(8'hA2, a); i2c_stop();
        check(!a, "R2 select mismatch nack", a, 0);
        i2c_start(); send_byte(8'h20, a); i2c_stop();
        check(!a, "R2 type mismatch nack", a, 0);

        // R3, R4: write across the top, wrapping into protected space
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; wbuf[2] = 8'h77;
        i2c_start();
        send_byte(8'hA0, a); send_byte(8'hFE, a); ptr_m = 8'hFE;
        for (int i = 0; i < 3; i++) begin
            send_byte(wbuf[i], a);
            check(a, "R4 data ack incl protected", a, 1);
            if (ptr_m >= 8'd128) model[ptr_m] = wbuf[i];
            ptr_m++;
        end
        i2c_stop();
        // R11: immediate probe is refused
        i2c_start(); send_byte(8'hA0, a); i2c_stop();
        check(!a, "R11 busy nack", a, 0);
        poll_ready(tries);
        check(tries < 40, "R11 ack after busy", tries, 40);

        // R7, R4: sequential read with wrap
        read_run(1'b1, 8'hFE, 4, "R7 sequential wrap");

        // R8: after NACK the slave stays released
        read_run(1'b1, 8'h80, 1, "R8 read before nack");
        i2c_start(); send_byte(8'hA1, a);
        recv_byte(1'b0, d); ptr_m++;
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R8 released after nack", d, 8'hFF);
        i2c_stop();

        // R9: byte without START is ignored, pointer unchanged
        scl_m = 1'b0; tick(H);
        send_byte(8'hA1, a);
        check(!a, "R9 no start no ack", a, 0);
        scl_m = 1'b1; tick(H);
        read_run(1'b0, 8'h00, 1, "R9 pointer unchanged");

        // R10: SDA glitches while SCL high are filtered
        glitch_en = 1'b1;
        wbuf[0] = 8'hF7;
        do_write(8'h90, 1, "R10 glitched write");
        glitch_en = 1'b0;
        read_run(1'b1, 8'h90, 1, "R10 glitched data stored");

        // random mix
        for (int it = 0; it < 12; it++) begin
            int op, n;
            logic [7:0] ad;
            op = int'($urandom_range(0, 2));
            n  = int'($urandom_range(1, 4));
            ad = 8'($urandom_range(0, 255));
            if (op == 0) begin
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
                do_write(ad, n, "R3 random write");
            end else if (op == 1) begin
                read_run(1'b1, ad, n, "R7 random sequential read");
            end else begin
                read_run(1'b0, 8'h00, n, "R5 random current read");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule